// File: doc/BRIEF.md
# Parameterized Add/Subtract Ripple Cell

This block is a purely combinational arithmetic cell that adds or subtracts two operands. Each operand has its own width and its own signedness, and the result has a third width. Both operands are first brought to the result width, by sign or zero extension or by truncation. A B-invert control and a carry-in then feed a ripple carry chain.

With the invert control low and carry-in low the cell adds. With both high it computes A minus B in two's complement. Alongside the sum, it exposes two per-bit vectors:
- the half-sum of each position, which ignores the carry chain;
- the carry leaving each position.

Synthesis-level logic such as comparators and lookahead adders can build on these two vectors. Widths and signedness are fixed when the cell is instantiated.

Top module: `addsub_cell`

## Requirements
- R1: Operand A is brought to Y_WIDTH bits before use. When A_SIGNED is nonzero, A's top bit fills the added upper bits. Otherwise the added bits are zero. When A is wider than Y_WIDTH, only its low Y_WIDTH bits are kept.
- R2: Operand B is brought to Y_WIDTH bits by the same rule, governed by B_SIGNED.
- R3: With bi_i = 1 every bit of the extended B is complemented before use. With bi_i = 0 the extended B is used unchanged.
- R4: y_o equals the low Y_WIDTH bits of (extended A) + (effective B) + ci_i.
- R5: With bi_i = 1 and ci_i = 1, y_o equals extended A minus extended B, modulo 2^Y_WIDTH.
- R6: co_o[i] is the carry leaving bit position i. It is the majority of A bit i, effective B bit i and the carry entering position i, where the carry entering position 0 is ci_i. co_o[Y_WIDTH-1] is the carry out of the whole sum.
- R7: x_o[i] equals A bit i XOR effective B bit i. It does not depend on ci_i or on any carry.
- R8: With bi_i = 1 and ci_i = 1, co_o[Y_WIDTH-1] is 1 exactly when extended A is greater than or equal to extended B, with both read as unsigned values.
- R9: The cell holds no state. All outputs follow the current inputs with no clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | A_WIDTH | Operand A |
| b_i | input | B_WIDTH | Operand B |
| ci_i | input | 1 | Carry into bit 0 |
| bi_i | input | 1 | Complement the extended B when 1 |
| y_o | output | Y_WIDTH | Sum |
| x_o | output | Y_WIDTH | Per-bit half-sum (A XOR effective B) |
| co_o | output | Y_WIDTH | Carry leaving each bit position |

## Verification
The assertions are evaluated inside the same combinational process that computes the values they inspect, so any partially updated input set is still self-consistent when it is checked. They are skipped whenever any input bit is unknown. The assertions assume that operands, carry-in and invert control are fully known, two-valued values. The bench drives only such values, changing them once per clock cycle after the rising edge and sampling at the falling edge.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

  // Full-adder sum bit.
  function automatic logic fa_sum(input logic a, input logic b, input logic c);
    return a ^ b ^ c;
  endfunction

  // Full-adder carry: majority of the three inputs.
  function automatic logic fa_carry(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/addsub_extend.sv
module addsub_extend #(
  parameter int unsigned IN_W   = 8,
  parameter int unsigned OUT_W  = 10,
  parameter bit          SIGNED = 1'b0
) (
  input  logic [IN_W-1:0]  in_i,
  output logic [OUT_W-1:0] out_o
);

  localparam int unsigned WIDE_W = OUT_W + IN_W;

  logic [WIDE_W-1:0] wide;

  generate
    if (SIGNED) begin : g_sign
      always_comb begin
        wide  = {{OUT_W{in_i[IN_W-1]}}, in_i};
        out_o = wide[OUT_W-1:0];
        if (!$isunknown(in_i) && (OUT_W >= IN_W))
          AST_SIGN_VALUE: assert ($signed(out_o) == $signed(in_i)); // R1 R2
      end
    end else begin : g_zero
      always_comb begin
        wide  = {{OUT_W{1'b0}}, in_i};
        out_o = wide[OUT_W-1:0];
        if (!$isunknown(in_i) && (OUT_W >= IN_W))
          AST_ZERO_VALUE: assert (out_o == in_i); // R1 R2
      end
    end
  endgenerate

endmodule

// File: rtl/addsub_chain.sv
module addsub_chain
  import addsub_pkg::*;
#(
  parameter int unsigned W = 10
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         ci_i,
  input  logic         bi_i,
  output logic [W-1:0] y_o,
  output logic [W-1:0] x_o,
  output logic [W-1:0] co_o
);

  localparam int unsigned FW = W + 1;

  logic [W-1:0]  b_eff;
  logic [FW-1:0] full_sum;
  logic [FW-1:0] carry_in_v;

  always_comb begin
    logic c;
    c     = ci_i;
    b_eff = b_i ^ {W{bi_i}};
    for (int i = 0; i < W; i++) begin
      x_o[i]  = a_i[i] ^ b_eff[i];
      y_o[i]  = fa_sum(a_i[i], b_eff[i], c);
      c       = fa_carry(a_i[i], b_eff[i], c);
      co_o[i] = c;
    end

    full_sum   = {1'b0, a_i} + {1'b0, b_eff} + FW'(ci_i);
    carry_in_v = {co_o, ci_i};

    if (!$isunknown({a_i, b_i, ci_i, bi_i})) begin
      AST_SUM_WHOLE: assert ({co_o[W-1], y_o} == full_sum); // R4
      AST_HALF_SUM: assert (y_o == (x_o ^ carry_in_v[W-1:0])); // R7
      AST_CARRY_GEN: assert ((co_o & ~(a_i | b_eff)) == '0); // R6
      if (bi_i && ci_i) begin
        AST_SUB_MOD: assert (y_o == W'(a_i - b_i)); // R5
        AST_BORROW: assert (co_o[W-1] == (a_i >= b_i)); // R8
      end
    end
  end

endmodule

// File: rtl/addsub_cell.sv
module addsub_cell #(
  parameter int unsigned A_WIDTH  = 8,
  parameter int unsigned B_WIDTH  = 5,
  parameter int unsigned Y_WIDTH  = 10,
  parameter bit          A_SIGNED = 1'b0,
  parameter bit          B_SIGNED = 1'b0
) (
  input  logic [A_WIDTH-1:0] a_i,
  input  logic [B_WIDTH-1:0] b_i,
  input  logic               ci_i,
  input  logic               bi_i,
  output logic [Y_WIDTH-1:0] y_o,
  output logic [Y_WIDTH-1:0] x_o,
  output logic [Y_WIDTH-1:0] co_o
);

  localparam int unsigned CW = Y_WIDTH;

  logic [CW-1:0] a_ext;
  logic [CW-1:0] b_ext;

  addsub_extend #(.IN_W(A_WIDTH), .OUT_W(CW), .SIGNED(A_SIGNED)) u_ext_a (
    .in_i  (a_i),
    .out_o (a_ext)
  );

  addsub_extend #(.IN_W(B_WIDTH), .OUT_W(CW), .SIGNED(B_SIGNED)) u_ext_b (
    .in_i  (b_i),
    .out_o (b_ext)
  );

  addsub_chain #(.W(CW)) u_chain (
    .a_i  (a_ext),
    .b_i  (b_ext),
    .ci_i (ci_i),
    .bi_i (bi_i),
    .y_o  (y_o),
    .x_o  (x_o),
    .co_o (co_o)
  );

endmodule

// File: tb/addsub_cell_tb_top.sv
`timescale 1ns/1ps
module addsub_cell_tb_top;

  localparam int AW = 8;
  localparam int BW = 5;
  localparam int YW = 10;
  localparam int NCFG = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [AW-1:0] a;
  logic [BW-1:0] b;
  logic          ci;
  logic          bi;

  logic [YW-1:0] y_w  [NCFG];
  logic [YW-1:0] x_w  [NCFG];
  logic [YW-1:0] co_w [NCFG];

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // Configuration k: A signed when k[0], B signed when k[1].
  for (genvar k = 0; k < NCFG; k++) begin : g_cfg
    addsub_cell #(
      .A_WIDTH(AW), .B_WIDTH(BW), .Y_WIDTH(YW),
      .A_SIGNED(k[0]), .B_SIGNED(k[1])
    ) dut_i (
      .a_i(a), .b_i(b), .ci_i(ci), .bi_i(bi),
      .y_o(y_w[k]), .x_o(x_w[k]), .co_o(co_w[k])
    );
  end

  // Behavioural reference model using integer arithmetic.
  task automatic ref_model(input int k, input int av, input int bv, input int c, input int inv,
                           output int ey, output int ex, output int eco);
    longint sa, sb, mask, ae, be, s, mi;
    mask = (64'd1 << YW) - 1;
    sa = av;
    sb = bv;
    if ((k & 1) && av >= (1 << (AW-1))) sa = av - (1 << AW);   // R1
    if ((k & 2) && bv >= (1 << (BW-1))) sb = bv - (1 << BW);   // R2
    ae = sa & mask;
    be = sb & mask;
    if (inv != 0) be = (~be) & mask;                           // R3
    s  = ae + be + c;
    ey = int'(s & mask);
    ex = int'(ae ^ be);
    eco = 0;
    for (int i = 0; i < YW; i++) begin
      mi = (64'd1 << (i + 1)) - 1;
      s  = (ae & mi) + (be & mi) + c;
      if (((s >> (i + 1)) & 1) != 0) eco = eco | (1 << i);
    end
  endtask

  task automatic check_val(input string tag, input int k, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s cfg=%0d a=%0h b=%0h ci=%0d bi=%0d actual=%0h expected=%0h",
               tag, k, a, b, ci, bi, act, exp);
    end
  endtask

  // Drive after the rising edge, check at the falling edge of the same cycle (R9).
  task automatic apply(input int av, input int bv, input int c, input int inv);
    int ey, ex, eco;
    string ytag;
    string ctag;
    @(posedge clk);
    #1;
    a  = AW'(av);
    b  = BW'(bv);
    ci = c[0];
    bi = inv[0];
    @(negedge clk);
    for (int k = 0; k < NCFG; k++) begin
      ref_model(k, av, bv, c, inv, ey, ex, eco);
      if (inv != 0 && c != 0)              ytag = "R5";
      else if (inv != 0)                   ytag = "R3";
      else if (av >= (1 << (AW-1)))        ytag = "R1";
      else if (bv >= (1 << (BW-1)))        ytag = "R2";
      else                                 ytag = "R4";
      ctag = (inv != 0 && c != 0) ? "R8" : "R6";
      check_val(ytag, k, int'(y_w[k]), ey);
      check_val("R7", k, int'(x_w[k]), ex);
      check_val(ctag, k, int'(co_w[k]), eco);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin : stim
    int avals [4];
    int bvals [4];
    a = '0; b = '0; ci = 1'b0; bi = 1'b0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // Quiescent state: zero operands give zero outputs (R4, R9).
    for (int k = 0; k < NCFG; k++) begin
      check_val("R4", k, int'(y_w[k]), 0);
      check_val("R6", k, int'(co_w[k]), 0);
    end

    // Corner operands: zero, all ones, sign boundaries.
    avals = '{0, 8'hFF, 8'h80, 8'h7F};
    bvals = '{0, 5'h1F, 5'h10, 5'h0F};
    foreach (avals[i])
      foreach (bvals[j])
        for (int m = 0; m < 4; m++)
          apply(avals[i], bvals[j], m & 1, (m >> 1) & 1);

    // X independence of carry-in: same a, b, bi with ci toggled (R7).
    apply(8'h5A, 5'h13, 0, 0);
    apply(8'h5A, 5'h13, 1, 0);
    apply(8'hC3, 5'h0A, 0, 1);
    apply(8'hC3, 5'h0A, 1, 1);

    // Random operands.
    for (int n = 0; n < 400; n++)
      apply($urandom_range(255), $urandom_range(31), $urandom_range(1), $urandom_range(1));

    finish_run();
  end

endmodule